// File: doc/BRIEF.md
# AHB Slave Response Protocol Monitor

This block is a passive checker for a single AHB slave port. It samples the select, transfer type, ready handshake, response code and current master identifier on every clock. It tracks the pipeline in which the address phase of one transfer overlaps the response phase of the transfer before it. When the slave's responses break the sequencing rules, it raises a violation flag. The flag stays set, and a cause code records the first violation found.

The monitor also keeps a bitmap with one bit per master. A bit is set when the slave gives a SPLIT response to that master. A bit is cleared when the slave signals completion of the split for that master. A completion for a master that has no split outstanding is a violation. The block drives no bus signal and does not check data values, burst addresses or arbitration.

Top module: `ahb_slave_monitor`

## Requirements
- R1: Synchronous active-high reset clears the flag and the cause code (code 0), drops any pending response phase and clears the split bitmap.
- R2: A transfer is accepted only in a cycle with select and ready both high. The transfer type field is read with bit 1 as the MSB: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ. A cycle that is not accepted opens no response phase.
- R3: After an accepted IDLE or BUSY transfer, the next cycle must show ready high with OKAY. Anything else, including a wait state, is violation code 1.
- R4: After an accepted NONSEQ or SEQ transfer, any number of wait states (ready low, OKAY) followed by OKAY with ready high is legal.
- R5: The response field is read with bit 1 as the MSB: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT. A non-OKAY response must take exactly two cycles: ready low in the first, ready high in the second, with the same code in both. A non-OKAY code with ready high in its first cycle, or a second cycle that differs from this shape, is violation code 2.
- R6: A request presented during the first cycle of a two-cycle response is ignored. It creates no response obligation of its own.
- R7: A non-OKAY response while no transfer is in its response phase is violation code 3.
- R8: The first cycle of a SPLIT response sets the bit of the master that owns that transfer. A completion bit raised for a master whose bit is clear is violation code 4. Every completion clears that master's bit.
- R9: The flag is sticky until reset, and the code keeps the first cause. If a response violation and a split violation occur in the same cycle, the response cause is recorded.
- R10: Both outputs are registered. A violation present in the inputs of one cycle appears on the outputs just after the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Slave select |
| trans_i | input | 2 | Transfer type |
| ready_i | input | 1 | Bus ready handshake |
| resp_i | input | 2 | Slave response code |
| mid_i | input | MID_W | Identifier of the master owning the address phase |
| split_done_i | input | 2**MID_W | Split completion, one bit per master |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Cause of the first violation (0 none, 1 to 4 as above) |

## Verification
The hardest situation to reach is the first cycle of a two-cycle response that overlaps a new request. The monitor must drop that request and still match the second response cycle against the code it saved. The stimulus opens a RETRY with ready low and presents a BUSY request with select high in that same cycle. It then completes the RETRY. If the ignored BUSY had been captured, it would have demanded OKAY. The same-cycle priority case is reached by raising an unknown split completion together with a stray error response. The split bitmap is observed only through completions, first legal and then repeated.

// File: rtl/ahbmon_pkg.sv
package ahbmon_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_e;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE   = 3'd0,
    CZ_NOWAIT = 3'd1,
    CZ_SHAPE  = 3'd2,
    CZ_STRAY  = 3'd3,
    CZ_SPLIT  = 3'd4
  } cause_e;
endpackage

// File: rtl/ahbmon_resp_tracker.sv
module ahbmon_resp_tracker
  import ahbmon_pkg::*;
#(
  parameter int MID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_i,
  input  logic [1:0]       trans_i,
  input  logic             ready_i,
  input  logic [1:0]       resp_i,
  input  logic [MID_W-1:0] mid_i,
  output logic             viol_o,
  output cause_e           cause_o,
  output logic             split_set_o,
  output logic [MID_W-1:0] split_mid_o,
  output logic             pend_o
);
  logic             pend_q, pend_d;
  logic             long_q, long_d;
  logic             second_q, second_d;
  logic [1:0]       code_q, code_d;
  logic [MID_W-1:0] mid_q, mid_d;

  always_comb begin
    viol_o      = 1'b0;
    cause_o     = CZ_NONE;
    split_set_o = 1'b0;
    pend_d      = pend_q;
    long_d      = long_q;
    second_d    = second_q;
    code_d      = code_q;
    mid_d       = mid_q;
    if (pend_q) begin
      if (second_q) begin
        if (!(ready_i && resp_i == code_q)) begin
          viol_o  = 1'b1;
          cause_o = CZ_SHAPE;
        end
        pend_d   = 1'b0;
        second_d = 1'b0;
      end else if (!long_q) begin
        if (!(ready_i && resp_i == RS_OKAY)) begin
          viol_o  = 1'b1;
          cause_o = CZ_NOWAIT;
        end
        pend_d = 1'b0;
      end else if (resp_i == RS_OKAY) begin
        if (ready_i) pend_d = 1'b0;
      end else if (ready_i) begin
        viol_o  = 1'b1;
        cause_o = CZ_SHAPE;
        pend_d  = 1'b0;
      end else begin
        second_d    = 1'b1;
        code_d      = resp_i;
        split_set_o = (resp_i == RS_SPLIT);
      end
    end else if (resp_i != RS_OKAY) begin
      viol_o  = 1'b1;
      cause_o = CZ_STRAY;
    end
    if (sel_i && ready_i) begin
      pend_d   = 1'b1;
      long_d   = (trans_i == TR_NONSEQ) || (trans_i == TR_SEQ);
      mid_d    = mid_i;
      second_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      long_q   <= 1'b0;
      second_q <= 1'b0;
      code_q   <= 2'b00;
      mid_q    <= '0;
    end else begin
      pend_q   <= pend_d;
      long_q   <= long_d;
      second_q <= second_d;
      code_q   <= code_d;
      mid_q    <= mid_d;
    end
  end

  assign split_mid_o = mid_q;
  assign pend_o      = pend_q;

  // R5: the closing cycle of a two-cycle response always follows a low-ready cycle
  p_second_after_low_r5: assert property (@(posedge clk) disable iff (rst)
    second_q |-> $past(!ready_i));
  // R5: the saved code equals the response seen in the opening cycle
  p_code_match_r5: assert property (@(posedge clk) disable iff (rst)
    second_q |-> (code_q == $past(resp_i)));
endmodule

// File: rtl/ahbmon_split_map.sv
module ahbmon_split_map #(
  parameter int MID_W   = 4,
  parameter int NUM_MST = 1 << MID_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_i,
  input  logic [MID_W-1:0]   set_mid_i,
  input  logic [NUM_MST-1:0] done_i,
  output logic               viol_o
);
  logic [NUM_MST-1:0] map_q;

  for (genvar k = 0; k < NUM_MST; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= (bit_q & ~done_i[k]) | (set_i && set_mid_i == MID_W'(k));
    end
    assign map_q[k] = bit_q;
  end

  assign viol_o = |(done_i & ~map_q);

  // R8: a completion without a simultaneous new split leaves those bits clear
  p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (done_i != '0 && !set_i) |=> ((map_q & $past(done_i)) == '0));
endmodule

// File: rtl/ahbmon_err_latch.sv
module ahbmon_err_latch
  import ahbmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               resp_viol_i,
  input  cause_e             resp_cause_i,
  input  logic               split_viol_i,
  output logic               err_o,
  output logic [CAUSE_W-1:0] code_o
);
  logic               err_q;
  logic [CAUSE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      code_q <= CZ_NONE;
    end else if (!err_q) begin
      if (resp_viol_i) begin
        err_q  <= 1'b1;
        code_q <= resp_cause_i;
      end else if (split_viol_i) begin
        err_q  <= 1'b1;
        code_q <= CZ_SPLIT;
      end
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst) err_q |=> err_q);
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst) err_q |=> $stable(code_q));
  p_code_set_r10: assert property (@(posedge clk) disable iff (rst) err_q |-> code_q != CZ_NONE);
endmodule

// File: rtl/ahb_slave_monitor.sv
module ahb_slave_monitor
  import ahbmon_pkg::*;
#(
  parameter  int MID_W   = 4,
  localparam int NUM_MST = 1 << MID_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic [1:0]         trans_i,
  input  logic               ready_i,
  input  logic [1:0]         resp_i,
  input  logic [MID_W-1:0]   mid_i,
  input  logic [NUM_MST-1:0] split_done_i,
  output logic               err_o,
  output logic [CAUSE_W-1:0] err_code_o
);
  logic             trk_viol, trk_set, trk_pend, map_viol;
  cause_e           trk_cause;
  logic [MID_W-1:0] trk_mid;

  ahbmon_resp_tracker #(.MID_W(MID_W)) u_trk (
    .clk(clk), .rst(rst), .sel_i(sel_i), .trans_i(trans_i), .ready_i(ready_i),
    .resp_i(resp_i), .mid_i(mid_i), .viol_o(trk_viol), .cause_o(trk_cause),
    .split_set_o(trk_set), .split_mid_o(trk_mid), .pend_o(trk_pend)
  );

  ahbmon_split_map #(.MID_W(MID_W), .NUM_MST(NUM_MST)) u_map (
    .clk(clk), .rst(rst), .set_i(trk_set), .set_mid_i(trk_mid),
    .done_i(split_done_i), .viol_o(map_viol)
  );

  ahbmon_err_latch u_err (
    .clk(clk), .rst(rst), .resp_viol_i(trk_viol), .resp_cause_i(trk_cause),
    .split_viol_i(map_viol), .err_o(err_o), .code_o(err_code_o)
  );

  // R7: a response with nothing pending is flagged at the next edge
  p_stray_r7: assert property (@(posedge clk) disable iff (rst)
    (!trk_pend && resp_i != RS_OKAY) |=> err_o);
endmodule

// File: tb/sim_ahb_slave_monitor.sv
module sim_ahb_slave_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic [1:0]  trans = 2'b00;
  logic        ready = 1'b1;
  logic [1:0]  resp = 2'b00;
  logic [3:0]  mid = 4'd0;
  logic [15:0] done = 16'd0;
  logic        err;
  logic [2:0]  code;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  int         ph;      // 0 idle, 1 short owed, 2 long owed, 3 closing cycle
  logic [1:0] held;
  int         owner;
  bit [15:0]  smap;
  bit         merr;
  int         mcode;

  always #4 clk = ~clk;

  ahb_slave_monitor u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .trans_i(trans), .ready_i(ready),
    .resp_i(resp), .mid_i(mid), .split_done_i(done), .err_o(err), .err_code_o(code)
  );

  task automatic report(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input logic s, input logic [1:0] t, input logic r,
                       input logic [1:0] p, input logic [3:0] m, input logic [15:0] d);
    int c = 0;
    int nph = ph;
    bit newsplit = 0;
    if (ph == 0) begin
      if (p != 2'b00) c = 3;
    end else if (ph == 1) begin
      if (!(r && p == 2'b00)) c = 1;
      nph = 0;
    end else if (ph == 2) begin
      if (p == 2'b00) begin
        if (r) nph = 0;
      end else if (r) begin
        c = 2; nph = 0;
      end else begin
        nph = 3; held = p; newsplit = (p == 2'b11);
      end
    end else begin
      if (!(r && p == held)) c = 2;
      nph = 0;
    end
    for (int k = 0; k < 16; k++) begin
      if (d[k]) begin
        if (!smap[k] && c == 0) c = 4;
        smap[k] = 1'b0;
      end
    end
    if (newsplit) smap[owner] = 1'b1;
    if (s && r) begin
      nph = t[1] ? 2 : 1;
      owner = int'(m);
    end
    ph = nph;
    if (!merr && c != 0) begin
      merr = 1'b1;
      mcode = c;
    end
  endtask

  task automatic step(input logic s, input logic [1:0] t, input logic r, input logic [1:0] p,
                      input logic [3:0] m, input logic [15:0] d, input string tag);
    @(negedge clk);
    sel = s; trans = t; ready = r; resp = p; mid = m; done = d;
    model(s, t, r, p, m, d);
    @(posedge clk);
    #1;
    report({tag, " flag"}, int'(err), int'(merr));
    report({tag, " code"}, int'(code), mcode);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sel = 0; trans = 0; ready = 1; resp = 0; mid = 0; done = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ph = 0; held = 0; owner = 0; smap = 0; merr = 0; mcode = 0;
  endtask

  task automatic expect_code(input string tag, input int exp);
    #1;
    report(tag, int'(code), exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    report("R1 reset flag", int'(err), 0);
    report("R1 reset code", int'(code), 0);

    // R4 / R2: legal traffic with wait states and overlapped addresses
    step(1, 2'b10, 1, 2'b00, 4'd1, 16'd0, "R2 nonseq addr");
    step(0, 2'b00, 0, 2'b00, 4'd0, 16'd0, "R4 wait");
    step(0, 2'b00, 0, 2'b00, 4'd0, 16'd0, "R4 wait2");
    step(1, 2'b11, 1, 2'b00, 4'd1, 16'd0, "R4 okay + seq addr");
    step(1, 2'b00, 1, 2'b00, 4'd1, 16'd0, "R4 okay + idle addr");
    step(1, 2'b01, 1, 2'b00, 4'd1, 16'd0, "R3 okay + busy addr");
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'd0, "R3 busy okay");
    expect_code("R4 legal stream code", 0);

    // R3: IDLE answered with a wait state
    do_reset();
    step(1, 2'b00, 1, 2'b00, 4'd0, 16'd0, "R3 idle addr");
    step(0, 2'b00, 0, 2'b00, 4'd0, 16'd0, "R3 idle waited");
    expect_code("R3 nowait code", 1);

    // R3: BUSY answered with ERROR
    do_reset();
    step(1, 2'b01, 1, 2'b00, 4'd0, 16'd0, "R3 busy addr");
    step(0, 2'b00, 0, 2'b01, 4'd0, 16'd0, "R3 busy error");
    step(0, 2'b00, 1, 2'b01, 4'd0, 16'd0, "R3 tail");
    expect_code("R3 busy code", 1);

    // R5: legal ERROR then a mismatched RETRY
    do_reset();
    step(1, 2'b10, 1, 2'b00, 4'd0, 16'd0, "R5 addr");
    step(0, 2'b00, 0, 2'b01, 4'd0, 16'd0, "R5 error first");
    step(1, 2'b10, 1, 2'b01, 4'd0, 16'd0, "R5 error second + addr");
    expect_code("R5 legal error code", 0);
    step(0, 2'b00, 0, 2'b10, 4'd0, 16'd0, "R5 retry first");
    step(0, 2'b00, 1, 2'b01, 4'd0, 16'd0, "R5 retry bad second");
    expect_code("R5 mismatch code", 2);

    // R5: non-OKAY with ready high in its first cycle
    do_reset();
    step(1, 2'b11, 1, 2'b00, 4'd0, 16'd0, "R5 seq addr");
    step(0, 2'b00, 1, 2'b10, 4'd0, 16'd0, "R5 one-cycle retry");
    expect_code("R5 one-cycle code", 2);

    // R6: request during opening cycle of RETRY is ignored
    do_reset();
    step(1, 2'b10, 1, 2'b00, 4'd0, 16'd0, "R6 addr");
    step(1, 2'b01, 0, 2'b10, 4'd0, 16'd0, "R6 retry first + busy req");
    step(0, 2'b00, 1, 2'b10, 4'd0, 16'd0, "R6 retry second");
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'd0, "R6 quiet");
    expect_code("R6 ignored request code", 0);

    // R7 / R10: stray response, flag appears only after the edge
    do_reset();
    @(negedge clk);
    sel = 0; ready = 1; resp = 2'b01;
    model(0, 2'b00, 1, 2'b01, 4'd0, 16'd0);
    #1;
    report("R10 flag before edge", int'(err), 0);
    @(posedge clk);
    #1;
    report("R10 flag after edge", int'(err), 1);
    expect_code("R7 stray code", 3);

    // R2: unselected transfer opens no response phase
    do_reset();
    step(0, 2'b10, 1, 2'b00, 4'd0, 16'd0, "R2 unselected");
    step(0, 2'b00, 0, 2'b10, 4'd0, 16'd0, "R2 retry with nothing owed");
    expect_code("R2 unselected code", 3);

    // R8: split set, legal completion, repeated completion
    do_reset();
    step(1, 2'b10, 1, 2'b00, 4'd3, 16'd0, "R8 addr m3");
    step(0, 2'b00, 0, 2'b11, 4'd0, 16'd0, "R8 split first");
    step(0, 2'b00, 1, 2'b11, 4'd0, 16'd0, "R8 split second");
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'h0008, "R8 completion m3");
    expect_code("R8 legal completion code", 0);
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'h0008, "R8 repeat completion");
    expect_code("R8 repeat code", 4);

    // R8: completion for a master never split
    do_reset();
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'h0020, "R8 unknown m5");
    expect_code("R8 unknown code", 4);

    // R9: first cause held; later causes ignored
    do_reset();
    step(0, 2'b00, 1, 2'b11, 4'd0, 16'd0, "R9 stray split");
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'h0001, "R9 later split fault");
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'd0, "R9 hold");
    expect_code("R9 sticky code", 3);

    // R9: same-cycle priority of response cause over split cause
    do_reset();
    step(0, 2'b00, 1, 2'b01, 4'd0, 16'h0100, "R9 both at once");
    expect_code("R9 priority code", 3);

    // R1: reset clears sticky flag and split state
    do_reset();
    #1;
    report("R1 cleared flag", int'(err), 0);
    step(0, 2'b00, 1, 2'b00, 4'd0, 16'd0, "R1 quiet after reset");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule